// File: doc/BRIEF.md
# Three-Share Masked PRESENT Substitution Layer

This block applies the 4-bit PRESENT substitution to every nibble of a 64-bit state held as three Boolean shares. The recombined value of the outputs (the XOR of the three output shares) equals the substitution applied nibble by nibble to the recombined value of the inputs. No share on its own, and no pair of shares handled together, reveals the unmasked data. The block draws no fresh random bits. It relies on the caller to supply a uniform three-way sharing.

The cubic substitution is split into two identical quadratic layers with a per-share affine remap between them. Each quadratic layer produces each output share from only two of the three input shares, using a component function built from an affine input map, a small quadratic core and an affine output map. A register bank separates the two layers, so glitches in the first layer cannot reach logic that sees all three shares. A second register bank holds the outputs. A valid flag travels with the data. One new state is accepted every clock cycle and there is no backpressure. Key addition, the bit permutation and share generation belong to neighbouring blocks.

Top module: `ti_present_sbox`

## Requirements
- R1: While reset is held, and until the first valid input has passed through, `out_vld` is 0 and all three output shares are 0.
- R2: For every output beat, out_sh1 ^ out_sh2 ^ out_sh3 equals the PRESENT substitution (0..F maps to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2) applied to each nibble of in_sh1 ^ in_sh2 ^ in_sh3. The nibble at bits [4i+3:4i] of the output comes from the nibble at the same bits of the input. This holds for any split of the input into three shares.
- R3: An input presented with `in_vld` high before rising edge k appears with `out_vld` high after rising edge k+1. When `in_vld` is low before edge k, `out_vld` is low after edge k+1.
- R4: Inputs on consecutive cycles are all accepted and each produces its own correct output on consecutive cycles.
- R5: Each nibble lane depends only on its own input lane. A state with a different value in every lane produces the per-lane substitution in every lane.
- R6: A cycle that carries no valid data leaves all three output shares unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input shares are valid this cycle |
| in_sh1 | input | 64 | Input share 1 |
| in_sh2 | input | 64 | Input share 2 |
| in_sh3 | input | 64 | Input share 3 |
| out_vld | output | 1 | Output shares are valid |
| out_sh1 | output | 64 | Output share 1 |
| out_sh2 | output | 64 | Output share 2 |
| out_sh3 | output | 64 | Output share 3 |

## Verification
Every nibble value is sent in every lane, split with random masks. This separates a wrong core formula or affine table entry from a share-routing error, which would only show under nonzero masks. The same values are then sent with all masks zero, which isolates the unmasked datapath. A state with a distinct value in each lane detects swapped or crossed lanes. Long random streams with random gaps in valid test back-to-back acceptance, valid alignment and output holding during bubbles.

// File: rtl/ti_sbox_pkg.sv
package ti_sbox_pkg;

  // input-side linear map of each quadratic layer
  function automatic logic [3:0] map_pre(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'h0; 4'h1: r = 4'h1; 4'h2: r = 4'hA; 4'h3: r = 4'hB;
      4'h4: r = 4'h8; 4'h5: r = 4'h9; 4'h6: r = 4'h2; 4'h7: r = 4'h3;
      4'h8: r = 4'h4; 4'h9: r = 4'h5; 4'hA: r = 4'hE; 4'hB: r = 4'hF;
      4'hC: r = 4'hC; 4'hD: r = 4'hD; 4'hE: r = 4'h6; default: r = 4'h7;
    endcase
    return r;
  endfunction

  // output-side affine map of each quadratic layer
  function automatic logic [3:0] map_post(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'hC; 4'h1: r = 4'h9; 4'h2: r = 4'h8; 4'h3: r = 4'hD;
      4'h4: r = 4'h6; 4'h5: r = 4'h3; 4'h6: r = 4'h2; 4'h7: r = 4'h7;
      4'h8: r = 4'hA; 4'h9: r = 4'hF; 4'hA: r = 4'hE; 4'hB: r = 4'hB;
      4'hC: r = 4'h0; 4'hD: r = 4'h5; 4'hE: r = 4'h4; default: r = 4'h1;
    endcase
    return r;
  endfunction

  // affine remap between the two quadratic layers
  function automatic logic [3:0] map_mid(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'h8; 4'h1: r = 4'hF; 4'h2: r = 4'hD; 4'h3: r = 4'hA;
      4'h4: r = 4'hC; 4'h5: r = 4'hB; 4'h6: r = 4'h9; 4'h7: r = 4'hE;
      4'h8: r = 4'h4; 4'h9: r = 4'h3; 4'hA: r = 4'h1; 4'hB: r = 4'h6;
      4'hC: r = 4'h0; 4'hD: r = 4'h7; 4'hE: r = 4'h5; default: r = 4'h2;
    endcase
    return r;
  endfunction

  // quadratic core component on two shares u (own) and w (neighbour), bit 0 = LSB
  function automatic logic [3:0] quad_core(input logic [3:0] u, input logic [3:0] w);
    logic [3:0] r;
    r[0] = u[0];
    r[1] = u[1] ^ (w[1] & w[3]) ^ (w[2] & w[3]) ^ (w[3] & u[1])
                ^ (w[3] & u[2]) ^ (w[1] & u[3]) ^ (w[2] & u[3]);
    r[2] = u[2] ^ (w[1] & w[3]) ^ (w[3] & u[1]) ^ (w[1] & u[3]);
    r[3] = u[3];
    return r;
  endfunction

  // full two-share component of one quadratic layer
  function automatic logic [3:0] comp_fn(input logic [3:0] u, input logic [3:0] w);
    return map_post(quad_core(map_pre(u), map_pre(w)));
  endfunction

endpackage

// File: rtl/ti_share_fn.sv
// One output share of a quadratic layer across all lanes: reads exactly two shares.
module ti_share_fn
  import ti_sbox_pkg::*;
#(
  parameter int NIB     = 16,
  parameter bit MID_MAP = 1'b0,
  localparam int W      = NIB * 4
) (
  input  logic [W-1:0] sh_own,
  input  logic [W-1:0] sh_nbr,
  output logic [W-1:0] sh_res
);

  for (genvar i = 0; i < NIB; i++) begin : g_lane
    logic [3:0] lane_q;
    assign lane_q = comp_fn(sh_own[4*i +: 4], sh_nbr[4*i +: 4]);
    if (MID_MAP) begin : g_mid
      assign sh_res[4*i +: 4] = map_mid(lane_q);
    end else begin : g_plain
      assign sh_res[4*i +: 4] = lane_q;
    end
  end

endmodule

// File: rtl/ti_stage.sv
// Quadratic layer: three non-complete component functions.
module ti_stage #(
  parameter int NIB     = 16,
  parameter bit MID_MAP = 1'b0,
  localparam int W      = NIB * 4
) (
  input  logic [W-1:0] s1,
  input  logic [W-1:0] s2,
  input  logic [W-1:0] s3,
  output logic [W-1:0] o1,
  output logic [W-1:0] o2,
  output logic [W-1:0] o3
);

  // share 3 from (1,2), share 2 from (3,1), share 1 from (2,3)
  ti_share_fn #(.NIB(NIB), .MID_MAP(MID_MAP)) u_fn3 (.sh_own(s1), .sh_nbr(s2), .sh_res(o3));
  ti_share_fn #(.NIB(NIB), .MID_MAP(MID_MAP)) u_fn2 (.sh_own(s3), .sh_nbr(s1), .sh_res(o2));
  ti_share_fn #(.NIB(NIB), .MID_MAP(MID_MAP)) u_fn1 (.sh_own(s2), .sh_nbr(s3), .sh_res(o1));

endmodule

// File: rtl/ti_present_sbox.sv
module ti_present_sbox #(
  parameter int NIB = 16,
  localparam int W  = NIB * 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_sh1,
  input  logic [W-1:0] in_sh2,
  input  logic [W-1:0] in_sh3,
  output logic         out_vld,
  output logic [W-1:0] out_sh1,
  output logic [W-1:0] out_sh2,
  output logic [W-1:0] out_sh3
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // first quadratic layer plus the per-share remap
  logic [W-1:0] l1_sh1, l1_sh2, l1_sh3;
  ti_stage #(.NIB(NIB), .MID_MAP(1'b1)) u_layer1 (
    .s1(in_sh1), .s2(in_sh2), .s3(in_sh3),
    .o1(l1_sh1), .o2(l1_sh2), .o3(l1_sh3)
  );

  // separating register between the layers
  logic         mid_vld, mid_vld_nx;
  logic         mid_en;
  logic [W-1:0] mid_sh1, mid_sh2, mid_sh3;

  always_comb begin
    mid_vld_nx = in_vld;
    mid_en     = in_vld;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mid_vld <= 1'b0;
      mid_sh1 <= '0;
      mid_sh2 <= '0;
      mid_sh3 <= '0;
    end else begin
      mid_vld <= mid_vld_nx;
      if (mid_en) begin
        mid_sh1 <= l1_sh1;
        mid_sh2 <= l1_sh2;
        mid_sh3 <= l1_sh3;
      end
    end
  end

  // second quadratic layer
  logic [W-1:0] l2_sh1, l2_sh2, l2_sh3;
  ti_stage #(.NIB(NIB), .MID_MAP(1'b0)) u_layer2 (
    .s1(mid_sh1), .s2(mid_sh2), .s3(mid_sh3),
    .o1(l2_sh1), .o2(l2_sh2), .o3(l2_sh3)
  );

  // output register
  logic out_vld_nx;
  logic out_en;

  always_comb begin
    out_vld_nx = mid_vld;
    out_en     = mid_vld;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_vld <= 1'b0;
      out_sh1 <= '0;
      out_sh2 <= '0;
      out_sh3 <= '0;
    end else begin
      out_vld <= out_vld_nx;
      if (out_en) begin
        out_sh1 <= l2_sh1;
        out_sh2 <= l2_sh2;
        out_sh3 <= l2_sh3;
      end
    end
  end

endmodule

// File: rtl/ti_present_sbox_chk.sv
module ti_present_sbox_chk #(
  parameter int NIB = 16,
  localparam int W  = NIB * 4
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         in_vld,
  input logic [W-1:0] in_sh1,
  input logic [W-1:0] in_sh2,
  input logic [W-1:0] in_sh3,
  input logic         mid_vld,
  input logic         out_vld,
  input logic [W-1:0] out_sh1,
  input logic [W-1:0] out_sh2,
  input logic [W-1:0] out_sh3
);

  function automatic logic [3:0] plain_nib(input logic [3:0] v);
    logic [63:0] tbl;
    tbl = 64'h21748FE3DA09B65C;
    return tbl[4*v +: 4];
  endfunction

  function automatic logic [W-1:0] plain_state(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < NIB; i++) r[4*i +: 4] = plain_nib(v[4*i +: 4]);
    return r;
  endfunction

  // R3: valid appears two edges later
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld |=> ##1 out_vld);

  // R3: no valid without an input
  p_bubble_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_vld |=> ##1 !out_vld);

  // R4: every beat held between the layers moves on the next edge
  p_pipe_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    mid_vld |=> out_vld);

  // R2: recombined output matches the unmasked substitution
  p_value_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld |=> ##1 ((out_sh1 ^ out_sh2 ^ out_sh3) ==
                    plain_state($past(in_sh1 ^ in_sh2 ^ in_sh3, 2))));

  // R6: outputs hold through a bubble
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mid_vld |=> ($stable(out_sh1) && $stable(out_sh2) && $stable(out_sh3)));

endmodule

bind ti_present_sbox ti_present_sbox_chk #(.NIB(NIB)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_vld(in_vld),
  .in_sh1(in_sh1), .in_sh2(in_sh2), .in_sh3(in_sh3),
  .mid_vld(mid_vld), .out_vld(out_vld),
  .out_sh1(out_sh1), .out_sh2(out_sh2), .out_sh3(out_sh3)
);

// File: tb/tb_ti_present_sbox.sv
`timescale 1ns/1ps
module tb_ti_present_sbox;

  localparam int NIB = 16;
  localparam int W   = NIB * 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic [W-1:0] in_sh1, in_sh2, in_sh3;
  logic         out_vld;
  logic [W-1:0] out_sh1, out_sh2, out_sh3;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench-side expectation pipeline (entries for edges k+1 and k+2)
  logic         e1_v, e2_v;
  logic [W-1:0] e1_y, e2_y;
  logic [W-1:0] last_o1, last_o2, last_o3;
  bit           have_last;
  bit           prev_v;
  bit           lane_tag;
  bit           tag1, tag2;

  always #2.5 clk = ~clk;

  ti_present_sbox #(.NIB(NIB)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_sh1(in_sh1), .in_sh2(in_sh2), .in_sh3(in_sh3),
    .out_vld(out_vld), .out_sh1(out_sh1), .out_sh2(out_sh2), .out_sh3(out_sh3)
  );

  function automatic logic [3:0] ref_nib(input logic [3:0] v);
    case (v)
      4'h0: return 4'hC; 4'h1: return 4'h5; 4'h2: return 4'h6; 4'h3: return 4'hB;
      4'h4: return 4'h9; 4'h5: return 4'h0; 4'h6: return 4'hA; 4'h7: return 4'hD;
      4'h8: return 4'h3; 4'h9: return 4'hE; 4'hA: return 4'hF; 4'hB: return 4'h8;
      4'hC: return 4'h4; 4'hD: return 4'h7; 4'hE: return 4'h1; default: return 4'h2;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_state(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < NIB; i++) r[4*i +: 4] = ref_nib(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check the outputs due now, then drive the next input (at negedge)
  task automatic beat(input bit v, input logic [W-1:0] x, input bit zero_mask, input bit lanes);
    logic [W-1:0] m1, m2;
    @(negedge clk);
    check(out_vld == e2_v, "R3", {63'd0, out_vld}, {63'd0, e2_v});
    if (e2_v) begin
      if (tag2) check((out_sh1 ^ out_sh2 ^ out_sh3) == e2_y, "R5",
                      out_sh1 ^ out_sh2 ^ out_sh3, e2_y);
      else if (prev_v) check((out_sh1 ^ out_sh2 ^ out_sh3) == e2_y, "R4",
                      out_sh1 ^ out_sh2 ^ out_sh3, e2_y);
      else      check((out_sh1 ^ out_sh2 ^ out_sh3) == e2_y, "R2",
                      out_sh1 ^ out_sh2 ^ out_sh3, e2_y);
      last_o1 = out_sh1; last_o2 = out_sh2; last_o3 = out_sh3;
      have_last = 1'b1;
    end else if (have_last) begin
      check(out_sh1 == last_o1 && out_sh2 == last_o2 && out_sh3 == last_o3, "R6",
            out_sh1 ^ out_sh2 ^ out_sh3, last_o1 ^ last_o2 ^ last_o3);
    end
    prev_v = e2_v && e1_v;
    e2_v = e1_v; e2_y = e1_y; tag2 = tag1;
    m1 = zero_mask ? '0 : rnd64();
    m2 = zero_mask ? '0 : rnd64();
    in_vld = v;
    in_sh1 = x ^ m1 ^ m2;
    in_sh2 = m1;
    in_sh3 = m2;
    e1_v = v; e1_y = ref_state(x); tag1 = lanes;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_vld = 1'b0;
    in_sh1 = '0; in_sh2 = '0; in_sh3 = '0;
    e1_v = 0; e2_v = 0; e1_y = '0; e2_y = '0;
    have_last = 0; prev_v = 0; tag1 = 0; tag2 = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_vld == 1'b0, "R1", {63'd0, out_vld}, '0);
    check((out_sh1 | out_sh2 | out_sh3) == '0, "R1", out_sh1 | out_sh2 | out_sh3, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && out_sh1 == '0 && out_sh2 == '0 && out_sh3 == '0, "R1",
          out_sh1 | out_sh2 | out_sh3, '0);

    // R2: every value in every lane with random masks, back to back
    for (int v = 0; v < 16; v++) beat(1'b1, {NIB{v[3:0]}}, 1'b0, 1'b0);
    // R2: same with all masks zero
    for (int v = 0; v < 16; v++) beat(1'b1, {NIB{v[3:0]}}, 1'b1, 1'b0);
    beat(1'b0, '0, 1'b0, 1'b0);
    beat(1'b0, '0, 1'b0, 1'b0);
    // R5: distinct value per lane, both directions
    beat(1'b1, 64'hFEDCBA9876543210, 1'b0, 1'b1);
    beat(1'b1, 64'h0123456789ABCDEF, 1'b0, 1'b1);
    beat(1'b0, '0, 1'b0, 1'b0);
    beat(1'b1, 64'h0123456789ABCDEF, 1'b1, 1'b1);
    // R6: bubbles after a valid beat
    repeat (3) beat(1'b0, rnd64(), 1'b0, 1'b0);
    // R4/R2/R6: random stream with random gaps
    for (int n = 0; n < 3000; n++) beat(($urandom() % 4) != 0, rnd64(), 1'b0, 1'b0);
    repeat (3) beat(1'b0, '0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule